// File: doc/BRIEF.md
# Two-Wire Random-Read Sequencer

This block carries out one complete random read from a memory device on a two-wire serial bus. A single request pulse supplies a 7-bit device address and an 8-bit location. The block first writes the location to the device with the master transmitting. It then turns the bus around with a repeated START and fetches one byte with the master receiving. The bus is never released between the pointer write and the data read. No other master can therefore move the device's internal pointer in between, and the whole read is atomic.

The block does not toggle bus lines itself. It drives a separate byte-level master through a small command channel carrying start, repeated start, stop, write-byte and read-byte requests. That master reports when each command has completed, whether the device acknowledged a written byte, and the byte it received. If an acknowledge is missing after either address byte or after the location, the block closes the bus with a STOP and reports an error.

Top module: `i2c_rand_rd_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and cmd_valid_o are 0, and rdata_o is 0.
- R2: A go_i pulse while busy_o is 0 captures both addresses. From the next cycle, busy_o is 1 and the block requests START. Command codes on cmd_o are: 1 START, 2 repeated START, 3 STOP, 4 write byte, 5 read byte.
- R3: Without any negative acknowledge, the commands come in this exact order: START; write of {addr,0}; write of the location; repeated START; write of {addr,1}; read; STOP. The device byte is the 7-bit address in bits 7:1, with bit 0 set to 0 for write and 1 for read.
- R4: A command stays on cmd_valid_o and cmd_o unchanged until the cycle in which cmd_done_i is 1. The following command appears in the next cycle.
- R5: A STOP is never issued between the write phase and the read phase. Exactly one STOP is issued per sequence.
- R6: If cmd_done_i arrives for a write command with cmd_nack_i = 1 (device did not acknowledge), the next command is STOP and no further command follows. After that STOP completes, err_o pulses together with done_o.
- R7: cmd_nack_o is 1 during the read command, so the master answers the single byte with NOT ACK. It is 0 during every other command.
- R8: One cycle after the STOP completes, done_o is 1 for exactly one cycle and busy_o is 0. After a successful sequence, rdata_o holds the received byte until the next read completes.
- R9: A go_i pulse while busy_o is 1 is ignored. The running sequence keeps its original addresses, and no second sequence starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Request pulse that starts a read |
| slave_addr_i | input | 7 | Device address, captured on go_i |
| word_addr_i | input | 8 | Location to read, captured on go_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| err_o | output | 1 | One-cycle pulse with done_o when the sequence was aborted |
| rdata_o | output | 8 | Byte read from the device |
| cmd_valid_o | output | 1 | Command request to the byte master |
| cmd_o | output | 3 | Command code |
| cmd_wdata_o | output | 8 | Byte to send for a write command |
| cmd_nack_o | output | 1 | Acknowledge bit the master returns after a read (1 = NOT ACK) |
| cmd_done_i | input | 1 | Current command completed |
| cmd_nack_i | input | 1 | Device did not acknowledge the written byte |
| cmd_rdata_i | input | 8 | Byte received by a read command |

## Verification
The hardest situations to reach are the aborts at each of the three acknowledge points. Each needs the device to refuse at one exact write while the earlier writes succeed. The bench's byte-master model counts the write commands within a sequence and returns a negative acknowledge at a chosen index (first, second or third write). For each index it expects a truncated command list ending in a single STOP. A second hard case is a request that arrives in the middle of a sequence, carrying different addresses. The bench issues it while the model holds a command pending, and then confirms that the bytes written still carry the first addresses and that the bus stays quiet afterwards.

// File: rtl/i2c_rand_rd_seq.sv
module i2c_rand_rd_seq #(
  parameter int SLA_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [SLA_W-1:0] slave_addr_i,
  input  logic [SLA_W:0]   word_addr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [SLA_W:0]   rdata_o,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_o,
  output logic [SLA_W:0]   cmd_wdata_o,
  output logic             cmd_nack_o,
  input  logic             cmd_done_i,
  input  logic             cmd_nack_i,
  input  logic [SLA_W:0]   cmd_rdata_i
);
  localparam int BW = SLA_W + 1;
  localparam logic [2:0] C_NONE = 3'd0, C_START = 3'd1, C_RSTART = 3'd2,
                         C_STOP = 3'd3, C_WRITE = 3'd4, C_READ = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_WSLA, ST_WPTR, ST_RSTART, ST_RSLA, ST_READ, ST_STOP
  } st_t;

  st_t             st;
  logic [SLA_W-1:0] sla;
  logic [BW-1:0]   ptr;
  logic            abort;

  assign busy_o      = (st != ST_IDLE);
  assign cmd_valid_o = busy_o;
  assign cmd_nack_o  = (st == ST_READ);

  always_comb begin
    cmd_wdata_o = '0;
    case (st)
      ST_START:  cmd_o = C_START;
      ST_WSLA:   begin cmd_o = C_WRITE; cmd_wdata_o = {sla, 1'b0}; end
      ST_WPTR:   begin cmd_o = C_WRITE; cmd_wdata_o = ptr; end
      ST_RSTART: cmd_o = C_RSTART;
      ST_RSLA:   begin cmd_o = C_WRITE; cmd_wdata_o = {sla, 1'b1}; end
      ST_READ:   cmd_o = C_READ;
      ST_STOP:   cmd_o = C_STOP;
      default:   cmd_o = C_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sla     <= '0;
      ptr     <= '0;
      abort   <= 1'b0;
      rdata_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (st == ST_IDLE) begin
        if (go_i) begin
          sla   <= slave_addr_i;
          ptr   <= word_addr_i;
          abort <= 1'b0;
          st    <= ST_START;
        end
      end else if (cmd_done_i) begin
        case (st)
          ST_START:  st <= ST_WSLA;
          ST_WSLA:   if (cmd_nack_i) begin abort <= 1'b1; st <= ST_STOP; end
                     else st <= ST_WPTR;
          ST_WPTR:   if (cmd_nack_i) begin abort <= 1'b1; st <= ST_STOP; end
                     else st <= ST_RSTART;
          ST_RSTART: st <= ST_RSLA;
          ST_RSLA:   if (cmd_nack_i) begin abort <= 1'b1; st <= ST_STOP; end
                     else st <= ST_READ;
          ST_READ:   begin rdata_o <= cmd_rdata_i; st <= ST_STOP; end
          default:   begin done_o <= 1'b1; err_o <= abort; st <= ST_IDLE; end
        endcase
      end
    end
  end

  // R2
  start_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !busy_o) |=> (cmd_valid_o && cmd_o == C_START));
  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_done_i) |=> (cmd_valid_o && $stable(cmd_o) && $stable(cmd_wdata_o)));
  // R6
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_o == C_WRITE && cmd_done_i && cmd_nack_i) |=> (cmd_o == C_STOP));
  // R7
  rd_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_nack_o |-> (cmd_valid_o && cmd_o == C_READ));
  // R8
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_o == C_STOP && cmd_done_i) |=> (done_o && !busy_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

// File: tb/i2c_rand_rd_seq_test.sv
module i2c_rand_rd_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, go_i = 1'b0;
  logic [6:0] slave_addr_i = '0;
  logic [7:0] word_addr_i = '0, rdata_o, cmd_wdata_o, cmd_rdata_i = '0;
  logic busy_o, done_o, err_o, cmd_valid_o, cmd_nack_o;
  logic [2:0] cmd_o;
  logic cmd_done_i = 1'b0, cmd_nack_i = 1'b0;

  always #5 clk = ~clk;

  i2c_rand_rd_seq uut (.*);

  int tests = 0, fails = 0;
  int nack_at = 0, wr_idx = 0, lat = 1, stops = 0;
  logic [7:0] dev_byte = '0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [7:0] d, input logic n, input string tag);
    exp_q.push_back({c, d, n});
    tag_q.push_back(tag);
  endtask

  // byte-level master model and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid_o) begin
        logic [2:0] c;
        logic [11:0] got;
        c = cmd_o;
        got = {cmd_o, (cmd_o == 3'd4) ? cmd_wdata_o : 8'h00, cmd_nack_o};
        if (c == 3'd3) stops++;
        if (exp_q.size() == 0) chk("R3 unexpected command", {20'h0, got}, 32'h0);
        else begin
          string t;
          logic [11:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {20'h0, got}, {20'h0, e});
        end
        for (int i = 0; i < lat; i++) @(negedge clk);
        chk("R4 command held", {29'h0, cmd_o}, {29'h0, c});
        if (c == 3'd4) wr_idx++;
        cmd_nack_i = (c == 3'd4) && (wr_idx == nack_at);
        cmd_rdata_i = (c == 3'd5) ? dev_byte : 8'hxx;
        cmd_done_i = 1'b1;
        @(negedge clk);
        cmd_done_i = 1'b0;
        cmd_nack_i = 1'b0;
      end
    end
  end

  task automatic run_rd(input logic [6:0] a, input logic [7:0] p, input int nk,
                        input logic [7:0] d, input int l, input bit inject);
    bit seen;
    logic [7:0] prev;
    prev = rdata_o;
    wr_idx = 0; nack_at = nk; dev_byte = d; lat = l; stops = 0;
    push(3'd1, 8'h00, 1'b0, "R2 START first");
    push(3'd4, {a, 1'b0}, 1'b0, "R3 write device byte");
    if (nk == 1) push(3'd3, 8'h00, 1'b0, "R6 stop after nack");
    else begin
      push(3'd4, p, 1'b0, "R3 write location");
      if (nk == 2) push(3'd3, 8'h00, 1'b0, "R6 stop after nack");
      else begin
        push(3'd2, 8'h00, 1'b0, "R5 repeated START");
        push(3'd4, {a, 1'b1}, 1'b0, "R3 read device byte");
        if (nk == 3) push(3'd3, 8'h00, 1'b0, "R6 stop after nack");
        else begin
          push(3'd5, 8'h00, 1'b1, "R7 read with NOT ACK");
          push(3'd3, 8'h00, 1'b0, "R3 final STOP");
        end
      end
    end
    @(negedge clk);
    slave_addr_i = a; word_addr_i = p; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    chk("R2 busy after go", {31'h0, busy_o}, 32'h1);
    if (inject) begin
      repeat (3) @(negedge clk);
      slave_addr_i = ~a; word_addr_i = ~p; go_i = 1'b1;
      @(negedge clk);
      go_i = 1'b0;
    end
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done_o) seen = 1;
      else @(negedge clk);
    end
    chk("R8 done pulse", {31'h0, seen}, 32'h1);
    chk("R8 idle at done", {31'h0, busy_o}, 32'h0);
    chk("R6 error flag", {31'h0, err_o}, {31'h0, (nk != 0)});
    chk("R8 read data", {24'h0, rdata_o}, {24'h0, (nk == 0) ? d : prev});
    chk("R5 single STOP", stops, 1);
    @(negedge clk);
    chk("R8 done one cycle", {31'h0, done_o}, 32'h0);
    chk("R3 all commands seen", exp_q.size(), 0);
    if (inject) begin
      repeat (8) @(negedge clk);
      chk("R9 no second sequence", {30'h0, cmd_valid_o, busy_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'h0, busy_o}, 32'h0);
    chk("R1 done/err", {30'h0, done_o, err_o}, 32'h0);
    chk("R1 cmd_valid", {31'h0, cmd_valid_o}, 32'h0);
    chk("R1 rdata", {24'h0, rdata_o}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {31'h0, busy_o}, 32'h0);
    run_rd(7'h50, 8'h3C, 0, 8'hA5, 1, 0);
    run_rd(7'h7F, 8'hFF, 0, 8'h5A, 4, 0);
    run_rd(7'h01, 8'h00, 0, 8'h00, 2, 0);
    run_rd(7'h2A, 8'h81, 1, 8'hEE, 2, 0);
    run_rd(7'h15, 8'h42, 2, 8'hEE, 1, 0);
    run_rd(7'h63, 8'h99, 3, 8'hEE, 3, 0);
    run_rd(7'h44, 8'h17, 0, 8'hC3, 5, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule